// File: doc/BRIEF.md
# Fixed-Priority Five-Source Interrupt Controller

This block sits between five interrupt request lines and a CPU core. The sources are: external line 0, timer 0, external line 1, a bus watchdog timer, and a serial-bus interface. A software-visible enable register holds one enable bit for each source and a master enable bit. The block masks the raw requests with this register. It chooses one winner by a fixed order, registers the handler address for that winner, and raises a request strobe to the CPU.

The design has one priority level. After the CPU acknowledges the strobe, the controller is in service and does not post another request. It stays that way until the CPU gives a return-from-handler pulse. A request that is still asserted at that point is taken on the next poll. The sequencing is done by a three-state machine:
- ST_IDLE: polling.
- ST_POSTED: the strobe is high and the vector is frozen.
- ST_SERVICE: the handler is running.

The machine has three transitions:
- ST_IDLE to ST_POSTED, when any enabled request is present.
- ST_POSTED to ST_SERVICE, on an acknowledge.
- ST_SERVICE to ST_IDLE, on a return pulse.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, cfg_rdata reads 0x00, cpu_irq is low and irq_active is low.
- R2: A write through cfg_we stores bit 7 (master enable) and bits 4..0 (per-source enables, with bit n for request line n) on the clock edge. cfg_rdata returns the stored value, and bits 6 and 5 always read 0.
- R3: While the master enable bit is 0, cpu_irq never rises, whatever the request lines and per-source bits hold.
- R4: While the master enable bit is 1, a request line n can raise cpu_irq only if enable bit n is 1.
- R5: Among enabled, asserted requests, the lowest line index wins. Line 0 is external 0, line 1 is timer 0, line 2 is external 1, line 3 is the bus timer, and line 4 is the serial-bus interface.
- R6: The vector for the winner on line n is 8*n + 3, which gives 0x003, 0x00B, 0x013, 0x01B and 0x023.
- R7: An enabled request that is present before a clock edge in ST_IDLE raises cpu_irq after that edge. cpu_irq and cpu_vec then hold unchanged until cpu_ack is sampled.
- R8: cpu_ack sampled while cpu_irq is high drops cpu_irq and sets irq_active on that edge. While irq_active is high, cpu_irq stays low for any request pattern.
- R9: cpu_reti sampled while irq_active is high clears irq_active on that edge. A request that is still enabled and asserted raises cpu_irq one edge later.
- R10: cpu_ack with no strobe posted, and cpu_reti outside service, have no effect on cpu_irq or irq_active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 5 | Raw request lines, index = priority rank (0 highest) |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write data |
| cfg_rdata | output | 8 | Enable register read value |
| cpu_irq | output | 1 | Request strobe to the CPU |
| cpu_vec | output | 11 | Handler address for the posted request |
| cpu_ack | input | 1 | CPU accepts the posted vector |
| cpu_reti | input | 1 | CPU return-from-handler pulse |
| irq_active | output | 1 | A handler is in service |

## Verification
The assertions check several behaviours on every cycle:
- The vector stays frozen while the strobe waits for an acknowledge.
- The strobe stays silent during service.
- The acknowledge and return handshakes move the block between its states.
- A strobe rises only after an edge at which the master enable was set.
- Every posted vector lies on the 8-byte grid inside the five-slot table.
- The grant is never more than one-hot.
- Reserved bits read zero.

Only the bench's sweep can show which source wins for a given pattern. It drives every request pattern against every per-source enable mask, with the master bit both on and off. The bench also covers re-posting a request that is still held after return, and acknowledges or returns that arrive out of place.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POSTED  = 2'd1,
        ST_SERVICE = 2'd2
    } irq_seq_state_t;

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int NSRC    = 5,
    parameter int REG_W   = 8,
    parameter int GLB_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             glb_en,
    output logic [NSRC-1:0]  src_en
);

    localparam logic [REG_W-1:0] LIVE_MASK =
        REG_W'((1 << NSRC) - 1) | REG_W'(1 << GLB_BIT);

    logic            glb_q;
    logic [NSRC-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q <= 1'b0;
            en_q  <= '0;
        end else if (we) begin
            glb_q <= wdata[GLB_BIT];
            en_q  <= wdata[NSRC-1:0];
        end
    end

    // Assemble the read image bit by bit; unassigned positions are reserved.
    for (genvar b = 0; b < REG_W; b++) begin : g_rd
        if (b < NSRC) begin : g_src
            assign rdata[b] = en_q[b];
        end else if (b == GLB_BIT) begin : g_glb
            assign rdata[b] = glb_q;
        end else begin : g_rsv
            assign rdata[b] = 1'b0;
        end
    end

    assign glb_en = glb_q;
    assign src_en = en_q;

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & LIVE_MASK)));  // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~LIVE_MASK) == '0);  // R2

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC       = 5,
    parameter int VEC_W      = 11,
    parameter int VEC_STRIDE = 8,
    parameter int VEC_OFS    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend,
    output logic             any,
    output logic [NSRC-1:0]  grant,
    output logic [VEC_W-1:0] vec
);

    // blk[i] is set when some line with a smaller index is pending.
    logic [NSRC:0] blk;

    assign blk[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign blk[i+1]  = blk[i] | pend[i];
        assign grant[i]  = pend[i] & ~blk[i];
    end

    assign any = blk[NSRC];

    always_comb begin
        vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                vec = vec | VEC_W'(VEC_OFS + i * VEC_STRIDE);
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R5

    AST_GRANT_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (grant != '0));  // R5

endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
    parameter int VEC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_any,
    input  logic [VEC_W-1:0] post_vec,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic             in_service
);

    import irq_pkg::*;

    irq_seq_state_t state_q, state_d;
    logic [VEC_W-1:0] vec_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (post_any) state_d = ST_POSTED;
            ST_POSTED:  if (cpu_ack)  state_d = ST_SERVICE;
            ST_SERVICE: if (cpu_reti) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // The vector is captured on the edge that posts the strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (state_q == ST_IDLE && post_any) begin
            vec_q <= post_vec;
        end
    end

    // Outputs.
    always_comb begin
        irq        = 1'b0;
        in_service = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_POSTED:  irq = 1'b1;
            ST_SERVICE: in_service = 1'b1;
            default:    ;
        endcase
    end

    assign vec = vec_q;

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cpu_ack) |=> (irq && $stable(vec)));  // R7

    AST_SILENT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !irq);  // R8

    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cpu_ack) |=> (in_service && !irq));  // R8

    AST_RETI_LEAVES_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && cpu_reti) |=> (!in_service && !irq));  // R9

    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !in_service && !post_any) |=> (!irq && !in_service));  // R10

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NSRC       = 5,
    parameter int REG_W      = 8,
    parameter int GLB_BIT    = 7,
    parameter int VEC_W      = 11,
    parameter int VEC_STRIDE = 8,
    parameter int VEC_OFS    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             cpu_irq,
    output logic [VEC_W-1:0] cpu_vec,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    output logic             irq_active
);

    localparam int VEC_TOP = VEC_OFS + (NSRC - 1) * VEC_STRIDE;

    logic             glb_en;
    logic [NSRC-1:0]  src_en;
    logic [NSRC-1:0]  pend;
    logic             pick_any;
    logic [NSRC-1:0]  pick_grant;
    logic [VEC_W-1:0] pick_vec;

    irq_enable_reg #(
        .NSRC    (NSRC),
        .REG_W   (REG_W),
        .GLB_BIT (GLB_BIT)
    ) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .glb_en (glb_en),
        .src_en (src_en)
    );

    assign pend = glb_en ? (src_req & src_en) : '0;

    irq_prio_pick #(
        .NSRC       (NSRC),
        .VEC_W      (VEC_W),
        .VEC_STRIDE (VEC_STRIDE),
        .VEC_OFS    (VEC_OFS)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .any   (pick_any),
        .grant (pick_grant),
        .vec   (pick_vec)
    );

    irq_seq #(
        .VEC_W (VEC_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_any   (pick_any),
        .post_vec   (pick_vec),
        .cpu_ack    (cpu_ack),
        .cpu_reti   (cpu_reti),
        .irq        (cpu_irq),
        .vec        (cpu_vec),
        .in_service (irq_active)
    );

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(cfg_rdata[GLB_BIT]));  // R3

    AST_SOURCE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> ($past(src_req & cfg_rdata[NSRC-1:0]) != '0));  // R4

    AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((32'(cpu_vec) % VEC_STRIDE) == VEC_OFS
                     && 32'(cpu_vec) <= VEC_TOP));  // R6

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_req = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cpu_irq;
    logic [10:0] cpu_vec;
    logic        cpu_ack = 1'b0;
    logic        cpu_reti = 1'b0;
    logic        irq_active;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cpu_irq    (cpu_irq),
        .cpu_vec    (cpu_vec),
        .cpu_ack    (cpu_ack),
        .cpu_reti   (cpu_reti),
        .irq_active (irq_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int winner(input logic [4:0] m);
        for (int i = 0; i < 5; i++) begin
            if (m[i]) return i;
        end
        return -1;
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #12;
        // R1: reset state
        chk(cfg_rdata == 8'h00, "R1 cfg_rdata", cfg_rdata, 0);
        chk(cpu_irq == 1'b0, "R1 cpu_irq", cpu_irq, 0);
        chk(irq_active == 1'b0, "R1 irq_active", irq_active, 0);
        rst_n = 1'b1;
        tick();

        // R2: reserved bits masked on readback
        write_cfg(8'hFF);
        chk(cfg_rdata == 8'h9F, "R2 readback ff", cfg_rdata, 8'h9F);
        write_cfg(8'h60);
        chk(cfg_rdata == 8'h00, "R2 readback 60", cfg_rdata, 0);

        // R10: stray ack/reti while idle
        src_req = '0;
        cpu_ack = 1'b1;
        cpu_reti = 1'b1;
        tick();
        cpu_ack = 1'b0;
        cpu_reti = 1'b0;
        chk(!cpu_irq && !irq_active, "R10 stray ack/reti", {cpu_irq, irq_active}, 0);

        // Sweep: master bit x per-source mask x request pattern
        for (int g = 0; g < 2; g++) begin
            for (int en = 0; en < 32; en++) begin
                for (int rq = 0; rq < 32; rq++) begin
                    logic [7:0] wv;
                    logic [4:0] m;
                    int w;
                    wv = {g[0], 2'b11, en[4:0]};
                    write_cfg(wv);
                    chk(cfg_rdata == (wv & 8'h9F), "R2 sweep readback", cfg_rdata, wv & 8'h9F);
                    m = g[0] ? (rq[4:0] & en[4:0]) : 5'd0;
                    w = winner(m);
                    src_req = rq[4:0];
                    tick();
                    if (w < 0) begin
                        chk(cpu_irq == 1'b0, g[0] ? "R4 masked no strobe" : "R3 master off",
                            cpu_irq, 0);
                        src_req = '0;
                        tick();
                    end else begin
                        chk(cpu_irq == 1'b1, "R4 enabled strobe", cpu_irq, 1);
                        chk(cpu_vec == 11'(8 * w + 3), "R5 R6 vector", cpu_vec, 8 * w + 3);
                        src_req = ~rq[4:0];
                        tick();
                        chk(cpu_irq && cpu_vec == 11'(8 * w + 3), "R7 held until ack",
                            cpu_vec, 8 * w + 3);
                        cpu_ack = 1'b1;
                        tick();
                        cpu_ack = 1'b0;
                        chk(!cpu_irq && irq_active, "R8 ack enters service",
                            {cpu_irq, irq_active}, 1);
                        src_req = 5'h1F;
                        tick();
                        chk(!cpu_irq, "R8 silent in service", cpu_irq, 0);
                        src_req = '0;
                        cpu_reti = 1'b1;
                        tick();
                        cpu_reti = 1'b0;
                        chk(!irq_active && !cpu_irq, "R9 reti clears", {cpu_irq, irq_active}, 0);
                        tick();
                        chk(!cpu_irq, "R9 nothing pending", cpu_irq, 0);
                    end
                end
            end
        end

        // R9: held request re-posted after return
        write_cfg(8'h9F);
        src_req = 5'b01000;
        tick();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
        chk(!cpu_irq && !irq_active, "R9 idle after reti", {cpu_irq, irq_active}, 0);
        tick();
        chk(cpu_irq && cpu_vec == 11'h01B, "R9 re-post", cpu_vec, 11'h01B);

        // R10: reti while posted (not in service) has no effect
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
        chk(cpu_irq && !irq_active, "R10 reti while posted", {cpu_irq, irq_active}, 2);
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        src_req = '0;
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;

        // R5: serial-bus line loses to every other line
        src_req = 5'b10010;
        tick();
        chk(cpu_vec == 11'h00B, "R5 timer0 beats serial", cpu_vec, 11'h00B);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule